// File: doc/BRIEF.md
# Error-Tagged Serial Receive Queue

This block is the receive-side character buffer of a serial port. A deserializer in front of it presents each received character together with two line-error indications: a parity mismatch and a bad stop bit. The block stores the character and both indications as a single 10-bit entry in a 16-entry first-in first-out queue. Because the errors travel with the character, software can tell which character in a burst was damaged.

Software takes entries out with a one-cycle read strobe. The popped entry appears on the read-data port one clock later. The queue reports its occupancy in a packed 16-bit index word. That word also carries the transmit-side occupancy, which comes in on an input port. The block also drives almost-full, full and a sticky overrun flag.

A one-cycle flush request empties the queue and clears the overrun flag. A busy indication shows that the flush is in progress, and it clears by itself once the flush is done.

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty, the receive field of the index word is 0, `rd_data` is 0, and `almost_full`, `full`, `overrun` and `flush_busy` are all low.
- R2: An accepted push stores {frame_err, parity_err, char}, so bit 9 is the framing flag, bit 8 is the parity flag and bits 7:0 are the character. Entries are popped in arrival order. A pop strobe in cycle k shows the head entry on `rd_data` after the clock edge that ends cycle k, and `rd_data` holds that value until the next pop.
- R3: `fifo_index` bits 12:8 give the receive occupancy (0 to 16), and bits 4:0 copy the `tx_level` input. Bits 15:13 and 7:5 read as zero.
- R4: `full` is high exactly when 16 entries are stored. A push while the queue is full is discarded, and the stored entries are left unchanged.
- R5: A push while the queue is full sets `overrun`. The flag stays set until a flush completes or reset is applied.
- R6: `almost_full` is high exactly when the occupancy is 12 or more.
- R7: A pop strobe on an empty queue loads 0 into `rd_data` and leaves the occupancy at 0.
- R8: A push and a pop in the same cycle on a queue holding 1 to 15 entries leave the occupancy unchanged. On an empty queue the push is stored and the pop returns 0. On a full queue the pop is taken and the push is discarded as an overrun.
- R9: A `flush_req` pulse raises `flush_busy` after the next edge. At the edge after that, the queue empties, `overrun` and `rd_data` clear, and `flush_busy` drops unless another request arrived. Push and pop strobes are ignored while `flush_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Deserializer presents a character this cycle |
| push_char | input | 8 | Received character |
| push_parity_err | input | 1 | Parity mismatch seen on this character |
| push_frame_err | input | 1 | Bad stop bit seen on this character |
| pop_strobe | input | 1 | Software read of the queue head |
| flush_req | input | 1 | Software request to empty the queue |
| tx_level | input | 5 | Transmit queue occupancy to be packed into the index word |
| rd_data | output | 10 | Last popped entry: {frame, parity, char} |
| fifo_index | output | 16 | Packed occupancy word |
| almost_full | output | 1 | Occupancy is at least 12 |
| full | output | 1 | Occupancy is 16 |
| overrun | output | 1 | Sticky: a push was lost to a full queue |
| flush_busy | output | 1 | Flush in progress; clears by itself |

## Verification
Every output of the block comes from a register, apart from the `tx_level` field of the index word, which follows its input at once. A push, pop or flush-request strobe driven in one cycle is therefore visible after exactly one clock edge. A completed flush is visible one edge after `flush_busy` rises. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares every output at the following falling edge, so each result is read in the cycle it is due and never a cycle early or late.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W  = 8;
    localparam int ENTRY_W = CHAR_W + 2;

    typedef struct packed {
        logic              frame_err;
        logic              parity_err;
        logic [CHAR_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_flush_ctl.sv
module rxq_flush_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    output logic busy
);
    typedef struct packed {
        logic busy;
    } flush_st_t;

    flush_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.busy = flush_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;

    AST_BUSY_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !flush_req |=> !busy); // R9
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic             wr_en,
    output logic             rd_en,
    output logic             pop_zero,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             overrun
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             ovr;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     is_full, is_empty, take_push, take_pop;

    always_comb begin
        is_full   = (st_q.count == CNT_MAX);
        is_empty  = (st_q.count == '0);
        take_push = push && !is_full && !clear;
        take_pop  = pop && !is_empty && !clear;
        st_d      = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (take_push)
                st_d.wr_ptr = (st_q.wr_ptr == PTR_MAX) ? '0 : st_q.wr_ptr + PTR_W'(1);
            if (take_pop)
                st_d.rd_ptr = (st_q.rd_ptr == PTR_MAX) ? '0 : st_q.rd_ptr + PTR_W'(1);
            if (take_push && !take_pop)
                st_d.count = st_q.count + CNT_W'(1);
            else if (take_pop && !take_push)
                st_d.count = st_q.count - CNT_W'(1);
            if (push && is_full)
                st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en    = take_push;
    assign rd_en    = take_pop;
    assign pop_zero = pop && is_empty && !clear;
    assign wr_ptr   = st_q.wr_ptr;
    assign rd_ptr   = st_q.rd_ptr;
    assign count    = st_q.count;
    assign overrun  = st_q.ovr;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_MAX); // R3
    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) && push && !pop && !clear |=> count == CNT_MAX); // R4
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !clear |=> overrun); // R5
    AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) && pop && !push && !clear |=> count == '0); // R7
    AST_PAIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && !clear && (count != '0) && (count != CNT_MAX)
        |=> $stable(count)); // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0) && !overrun); // R9
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  rxq_entry_t       wr_entry,
    input  logic             rd_en,
    input  logic             pop_zero,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic             clear,
    output rxq_entry_t       rd_entry
);
    typedef struct packed {
        logic [DEPTH-1:0][ENTRY_W-1:0] mem;
        logic [ENTRY_W-1:0]            rdata;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en)
            st_d.mem[wr_ptr] = wr_entry;
        if (clear || pop_zero)
            st_d.rdata = '0;
        else if (rd_en)
            st_d.rdata = st_q.mem[rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_entry = rxq_entry_t'(st_q.rdata);

    AST_ZERO_ON_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop_zero |=> rd_entry == '0); // R7
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && !pop_zero && !clear |=> $stable(rd_entry)); // R2
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int AFULL_LVL  = 12,
    parameter int TX_CNT_W   = 5,
    localparam int PTR_W     = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int IDX_W     = 16,
    localparam int RX_LSB    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_valid,
    input  logic [CHAR_W-1:0]   push_char,
    input  logic                push_parity_err,
    input  logic                push_frame_err,
    input  logic                pop_strobe,
    input  logic                flush_req,
    input  logic [TX_CNT_W-1:0] tx_level,
    output logic [ENTRY_W-1:0]  rd_data,
    output logic [IDX_W-1:0]    fifo_index,
    output logic                almost_full,
    output logic                full,
    output logic                overrun,
    output logic                flush_busy
);
    logic             busy, wr_en, rd_en, pop_zero;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    rxq_entry_t       in_entry, out_entry;

    always_comb begin
        in_entry.frame_err  = push_frame_err;
        in_entry.parity_err = push_parity_err;
        in_entry.data       = push_char;
    end

    rxq_flush_ctl u_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (flush_req),
        .busy      (busy)
    );

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_valid),
        .pop      (pop_strobe),
        .clear    (busy),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .pop_zero (pop_zero),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (count),
        .overrun  (overrun)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .wr_entry (in_entry),
        .rd_en    (rd_en),
        .pop_zero (pop_zero),
        .rd_ptr   (rd_ptr),
        .clear    (busy),
        .rd_entry (out_entry)
    );

    always_comb begin
        fifo_index                        = '0;
        fifo_index[TX_CNT_W-1:0]          = tx_level;
        fifo_index[RX_LSB +: CNT_W]       = count;
    end

    assign rd_data     = out_entry;
    assign almost_full = (count >= CNT_W'(AFULL_LVL));
    assign full        = (count == CNT_W'(DEPTH));
    assign flush_busy  = busy;

    AST_FULL_IMPLIES_AFULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full); // R6
    AST_FLUSH_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> flush_busy); // R9
endmodule

// File: tb/tb_rxq_top.sv
module tb_rxq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_char = '0;
    logic       push_parity_err = 1'b0;
    logic       push_frame_err = 1'b0;
    logic       pop_strobe = 1'b0;
    logic       flush_req = 1'b0;
    logic [4:0] tx_level = '0;
    logic [9:0] rd_data;
    logic [15:0] fifo_index;
    logic       almost_full, full, overrun, flush_busy;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [9:0] mq[$];
    logic [9:0] m_rdata = '0;
    bit         m_ovr = 1'b0;
    bit         m_busy = 1'b0;

    always #10 clk = ~clk;

    rxq_top dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_char(push_char),
        .push_parity_err(push_parity_err), .push_frame_err(push_frame_err),
        .pop_strobe(pop_strobe), .flush_req(flush_req), .tx_level(tx_level),
        .rd_data(rd_data), .fifo_index(fifo_index), .almost_full(almost_full),
        .full(full), .overrun(overrun), .flush_busy(flush_busy)
    );

    function automatic logic [15:0] exp_index(int cnt, logic [4:0] tx);
        logic [15:0] v;
        v = '0;
        v[12:8] = 5'(cnt);
        v[4:0] = tx;
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check("R2 rd_data", 32'(rd_data), 32'(m_rdata));
        check("R3 fifo_index", 32'(fifo_index), 32'(exp_index(mq.size(), tx_level)));
        check("R4 full", 32'(full), 32'(mq.size() == 16));
        check("R5 overrun", 32'(overrun), 32'(m_ovr));
        check("R6 almost_full", 32'(almost_full), 32'(mq.size() >= 12));
        check("R9 flush_busy", 32'(flush_busy), 32'(m_busy));
    endtask

    // Drive at the falling edge, update the model at the rising edge, check at the next falling edge.
    task automatic step(bit psh, logic [9:0] ent, bit pp, bit fl, logic [4:0] tx);
        int  sz;
        push_valid      = psh;
        push_char       = ent[7:0];
        push_parity_err = ent[8];
        push_frame_err  = ent[9];
        pop_strobe      = pp;
        flush_req       = fl;
        tx_level        = tx;
        @(posedge clk);
        if (m_busy) begin
            mq.delete();
            m_ovr   = 1'b0;
            m_rdata = '0;
        end else begin
            sz = mq.size();
            if (pp) begin
                if (sz > 0) m_rdata = mq.pop_front();
                else        m_rdata = '0;
            end
            if (psh) begin
                if (sz < 16) mq.push_back(ent);
                else         m_ovr = 1'b1;
            end
        end
        m_busy = fl;
        @(negedge clk);
        push_valid = 1'b0;
        pop_strobe = 1'b0;
        flush_req  = 1'b0;
        check_all();
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rd_data", 32'(rd_data), 0);
        check("R1 fifo_index", 32'(fifo_index), 0);
        check("R1 flags", 32'({almost_full, full, overrun, flush_busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: pop on empty returns zero, count stays 0
        step(1'b1, 10'h3A5, 1'b0, 1'b0, 5'd3);
        step(1'b0, '0, 1'b1, 1'b0, 5'd3);
        check("R2 tagged entry", 32'(rd_data), 32'h3A5);
        step(1'b0, '0, 1'b1, 1'b0, 5'd3);
        check("R7 empty pop data", 32'(rd_data), 0);
        check("R7 empty pop count", 32'(fifo_index[12:8]), 0);

        // R8: push+pop on empty stores push
        step(1'b1, 10'h155, 1'b1, 1'b0, 5'd16);
        check("R8 empty pair count", 32'(fifo_index[12:8]), 1);
        // fill to 16, watching R6 threshold
        for (int i = 0; i < 15; i++) begin
            step(1'b1, 10'(i * 37), 1'b0, 1'b0, 5'(i));
            if (i == 10) check("R6 at 12", 32'(almost_full), 1);
            if (i == 9)  check("R6 at 11", 32'(almost_full), 0);
        end
        check("R4 full at 16", 32'(full), 1);
        // R4/R5: push while full discarded, overrun set
        step(1'b1, 10'h2FF, 1'b0, 1'b0, 5'd0);
        check("R4 count held", 32'(fifo_index[12:8]), 16);
        check("R5 overrun set", 32'(overrun), 1);
        // R8: pair on full -> pop taken, push lost
        step(1'b1, 10'h1EE, 1'b1, 1'b0, 5'd0);
        check("R8 full pair count", 32'(fifo_index[12:8]), 15);
        check("R2 head after full", 32'(rd_data), 32'h155);
        // R8: pair in the middle keeps count
        step(1'b1, 10'h0AB, 1'b1, 1'b0, 5'd0);
        check("R8 mid pair count", 32'(fifo_index[12:8]), 15);
        check("R5 overrun sticky", 32'(overrun), 1);

        // R9: flush, with push/pop attempted while busy
        step(1'b0, '0, 1'b0, 1'b1, 5'd1);
        check("R9 busy raised", 32'(flush_busy), 1);
        step(1'b1, 10'h111, 1'b1, 1'b0, 5'd1);
        check("R9 emptied", 32'(fifo_index[12:8]), 0);
        check("R9 overrun cleared", 32'(overrun), 0);
        check("R9 busy dropped", 32'(flush_busy), 0);

        // random phases: fill-heavy, drain-heavy, balanced
        for (int ph = 0; ph < 30; ph++) begin
            int pp_pct, ps_pct;
            ps_pct = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 20 : 50;
            pp_pct = (ph % 3 == 0) ? 15 : (ph % 3 == 1) ? 80 : 50;
            for (int c = 0; c < 200; c++) begin
                step(($urandom % 100) < ps_pct, 10'($urandom), ($urandom % 100) < pp_pct,
                     ($urandom % 97) == 0, 5'($urandom % 17));
            end
        end
        // drain and confirm order
        for (int i = 0; i < 18; i++) step(1'b0, '0, 1'b1, 1'b0, 5'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule